// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers a set of level-sensitive interrupt request lines into one register-mapped slave and raises a single combined request toward a parent interrupt controller. Each line passes through a two-flop synchronizer. It is then gated by a per-line enable bit. The gated word forms the pending word that software reads.

Software never writes the enable word as a whole. It sets chosen enable bits through one write-only location and clears chosen bits through another. A third write-only location drops every enable bit in a single write. Pending bits are not latched. A bit stays set only while its source holds its line high, so a handler quiets the source and needs no acknowledge write. The bus port is a plain single-cycle port. A write takes effect at the clock edge that samples its strobe. Read data appears on the cycle after the read strobe.

Top module: `level_irq_ctrl`

## Requirements
- R1: With the default of 32 lines, bit i of the word read at offset 0x04 equals the synchronized level of line i ANDed with enable bit i.
- R2: After reset all enable bits are 0, so the pending word reads 0 even with every line high. `irq_req` and `bus_rdata` are 0 during and right after reset.
- R3: A write to offset 0x10 sets the enable bits where the write data holds a 1 and leaves the other enable bits unchanged.
- R4: A write to offset 0x0c clears the enable bits where the write data holds a 1 and leaves the other enable bits unchanged.
- R5: Any write to offset 0x08 clears every enable bit, whatever the write data.
- R6: Pending bits are level-sensitive. A pending bit drops once its line drops, with no acknowledge write.
- R7: `irq_req` is registered. It is 1 exactly when the pending word was nonzero at the previous clock edge.
- R8: Take a line change that is first sampled at clock edge k. A read strobe sampled at edge k+1 still returns the old level. A read strobe sampled at edge k+2 returns the new level.
- R9: A read strobe sampled at edge k places its data on `bus_rdata` after edge k. Reads of 0x08, 0x0c, 0x10 and of any unmapped offset return 0.
- R10: Writes to offset 0x04 and to unmapped offsets leave the enable bits unchanged.
- R11: Writes on consecutive cycles apply in order. When a set and a clear of the same bit come back to back, the later write decides that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_LINES | Level-sensitive request lines, asynchronous |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NUM_LINES | Write data (bit mask) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NUM_LINES | Registered read data |
| irq_req | output | 1 | Combined request to the parent controller |

## Verification
The bench builds the block with its defaults: 32 lines, an 8-bit offset and two synchronizer stages. At that size it can walk every line on its own through enable, pending and disable. It also covers the full set of mapped and a sample of unmapped offsets, and the edge-exact latency of both the read path and the combined request. Expected pending words are computed in the bench from a model of the enable mask ANDed with the driven line levels.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned OFS_PENDING = 32'h04;
  localparam int unsigned OFS_MASKALL = 32'h08;
  localparam int unsigned OFS_CLRBITS = 32'h0c;
  localparam int unsigned OFS_SETBITS = 32'h10;

  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_SET     = 2'd1,
    CMD_CLR     = 2'd2,
    CMD_CLR_ALL = 2'd3
  } en_cmd_e;
endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/lic_enable_bank.sv
module lic_enable_bank
  import lic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  en_cmd_e              cmd,
  input  logic [NUM_LINES-1:0] mask,
  output logic [NUM_LINES-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      unique case (cmd)
        CMD_SET:     en_q <= en_q | mask;
        CMD_CLR:     en_q <= en_q & ~mask;
        CMD_CLR_ALL: en_q <= '0;
        default:     en_q <= en_q;
      endcase
    end
  end

  // R2
  a_r2_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_q == '0));
  // R3
  a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SET) |=> ((en_q & $past(mask)) == $past(mask)));
  // R4
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLR) |=> ((en_q & $past(mask)) == '0));
  // R5
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLR_ALL) |=> (en_q == '0));
  // R10
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE) |=> $stable(en_q));
endmodule

// File: rtl/lic_reg_port.sv
module lic_reg_port
  import lic_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [NUM_LINES-1:0] pending,
  output en_cmd_e              cmd,
  output logic [NUM_LINES-1:0] rdata_q
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
  localparam logic [ADDR_W-1:0] A_MALL = ADDR_W'(OFS_MASKALL);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLRBITS);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_SETBITS);

  always_comb begin
    cmd = CMD_NONE;
    if (bus_wr) begin
      if      (bus_addr == A_SET)  cmd = CMD_SET;
      else if (bus_addr == A_CLR)  cmd = CMD_CLR;
      else if (bus_addr == A_MALL) cmd = CMD_CLR_ALL;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= (bus_addr == A_PEND) ? pending : '0;
    end
  end

  // R1
  a_r1_pending_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_PEND) |=> (rdata_q == $past(pending)));
  // R9
  a_r9_other_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != A_PEND) |=> (rdata_q == '0));
  // R10
  a_r10_no_cmd_pend: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_PEND) |-> (cmd == CMD_NONE));
endmodule

// File: rtl/level_irq_ctrl.sv
module level_irq_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  input  logic                 bus_rd,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 irq_req
);
  logic [NUM_LINES-1:0] lines_s;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] pending;
  en_cmd_e              cmd;
  logic                 irq_q;

  lic_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(irq_lines), .q_sync(lines_s)
  );

  lic_reg_port #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .pending(pending), .cmd(cmd), .rdata_q(bus_rdata)
  );

  lic_enable_bank #(.NUM_LINES(NUM_LINES)) u_en (
    .clk(clk), .rst(rst), .cmd(cmd), .mask(bus_wdata), .en_q(en_q)
  );

  assign pending = lines_s & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pending;
  end

  assign irq_req = irq_q;

  // R7
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req == ($past(pending) != '0)));
  // R2
  a_r2_irq_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_req);
endmodule

// File: tb/level_irq_ctrl_tb.sv
`timescale 1ns/1ps
module level_irq_ctrl_tb;
  localparam int N  = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  lines = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic          rd = 1'b0;
  logic [N-1:0]  wdata = '0;
  wire  [N-1:0]  rdata;
  wire           irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [N-1:0] en_m = '0;
  logic [N-1:0] v;

  always #4 clk = ~clk;

  level_irq_ctrl #(.NUM_LINES(N), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .irq_lines(lines), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata), .irq_req(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [N-1:0] o);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; o = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    lines = '1;
    repeat (4) @(negedge clk);
    chk("R2 rdata in reset", rdata, '0);
    chk("R2 irq in reset", {31'b0, irq}, '0);
    rst = 1'b0;
    settle();
    rd_reg(8'h04, v);
    chk("R2 pending after reset", v, '0);
    chk("R2 irq after reset", {31'b0, irq}, '0);

    // R3 / R1: enable one line at a time, all lines high
    for (int i = 0; i < N; i++) begin
      wr_reg(8'h10, N'(1) << i);
      en_m |= N'(1) << i;
      rd_reg(8'h04, v);
      chk("R3 set accumulates", v, lines & en_m);
    end

    // R1 / R6: line patterns with full enable
    for (int i = 0; i < N; i++) begin
      lines = ~(N'(1) << i);
      settle();
      rd_reg(8'h04, v);
      chk("R6 pending follows level", v, lines & en_m);
    end

    // R4: partial clear
    lines = '1;
    wr_reg(8'h0c, 32'h0F0F_0F0F);
    en_m &= ~32'h0F0F_0F0F;
    settle();
    rd_reg(8'h04, v);
    chk("R4 clear bits", v, lines & en_m);
    for (int i = 0; i < N; i++) begin
      lines = N'(1) << i;
      settle();
      rd_reg(8'h04, v);
      chk("R1 masked line", v, lines & en_m);
      chk("R7 irq per line", {31'b0, irq}, {31'b0, |(lines & en_m)});
    end

    // R10: ignored writes
    lines = '1;
    wr_reg(8'h04, '0);
    wr_reg(8'h00, '1);
    wr_reg(8'h14, '1);
    wr_reg(8'h09, '0);
    settle();
    rd_reg(8'h04, v);
    chk("R10 ignored writes", v, en_m);

    // R9: write-only and unmapped reads
    rd_reg(8'h08, v); chk("R9 read 0x08", v, '0);
    rd_reg(8'h0c, v); chk("R9 read 0x0c", v, '0);
    rd_reg(8'h10, v); chk("R9 read 0x10", v, '0);
    rd_reg(8'h00, v); chk("R9 read 0x00", v, '0);
    rd_reg(8'h05, v); chk("R9 read 0x05", v, '0);
    rd_reg(8'hFC, v); chk("R9 read 0xFC", v, '0);

    // R5: mask all with zero data
    wr_reg(8'h08, '0);
    en_m = '0;
    rd_reg(8'h04, v);
    chk("R5 mask all", v, '0);
    @(negedge clk);
    chk("R5 irq dropped", {31'b0, irq}, '0);

    // R11: back-to-back writes
    @(negedge clk); addr = 8'h10; wdata = 32'h0000_0003; wr = 1'b1;
    @(negedge clk); addr = 8'h0c; wdata = 32'h0000_0001;
    @(negedge clk); addr = 8'h0c; wdata = 32'h0000_0004;
    @(negedge clk); addr = 8'h10; wdata = 32'h0000_0004;
    @(negedge clk); wr = 1'b0; wdata = '0;
    en_m = 32'h0000_0006;
    rd_reg(8'h04, v);
    chk("R11 later write wins", v, en_m);

    // R8 / R7: edge-exact latency
    wr_reg(8'h10, '1);
    en_m = '1;
    lines = '0;
    settle();
    chk("R7 irq idle", {31'b0, irq}, '0);
    @(negedge clk); lines = 32'hA5A5_0001; addr = 8'h04; rd = 1'b1;
    @(negedge clk);
    chk("R8 read at edge k old", rdata, '0);
    @(negedge clk);
    chk("R8 read at edge k+1 old", rdata, '0);
    chk("R7 irq still low at k+1", {31'b0, irq}, '0);
    @(negedge clk);
    chk("R8 read at edge k+2 new", rdata, 32'hA5A5_0001);
    chk("R7 irq high at k+2", {31'b0, irq}, 32'h1);
    rd = 1'b0;

    // R6: drop line, no acknowledge
    lines = '0;
    settle();
    rd_reg(8'h04, v);
    chk("R6 drops without ack", v, '0);
    chk("R7 irq low after drop", {31'b0, irq}, '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule